// File: doc/BRIEF.md
# Configurable-Aspect Simple Dual-Port Block RAM

This block is a 16-kbit on-chip memory with one write-only port and one read-only port, each running on its own clock. The word width is fixed at elaboration to 1, 2, 4, 8 or 16 bits. The number of words scales inversely, so the total stays at 16384 bits. Both ports share a 14-bit byte-independent address bus. For a width of 2^k bits, the k least significant address bits are ignored. One bus layout therefore serves every shape.

Access on either port requires that port's clock enable and a 3-bit bank-select input that matches the block's bank parameter. This lets several instances share address and data wiring. The read side has two output modes, chosen by a parameter:
- **Bypass:** data appears one read-clock edge after the address.
- **Pipelined:** a second register, loaded under its own output enable, adds one cycle.

A synchronous read-side reset clears the output registers and leaves the stored words alone. Storage starts at all zeros.

Top module: `aspect_sdp_ram`

## Requirements
- R1: `DATA_W` must be one of 1, 2, 4, 8 or 16. The memory then holds 16384/`DATA_W` words. Any other value stops elaboration. Every legal width stores and returns data correctly.
- R2: The word addressed is `addr[13:log2(DATA_W)]`. The low log2(`DATA_W`) address bits have no effect on either port.
- R3: A word is written at a rising `wr_clk` edge only when `wr_ce`=1, `wr_en`=1 and `bank_sel`==`BANK_ID`. If any one of these is absent, nothing is stored.
- R4: With `PIPE_OUT`=0, `rd_data` takes the addressed word at the first rising `rd_clk` edge where `rd_ce`=1 and the bank matches. Otherwise it holds its value.
- R5: With `PIPE_OUT`=1, a second register copies the first-stage value at each `rd_clk` edge where `rd_oce`=1. This gives two cycles of latency. With `rd_oce`=0, `rd_data` holds.
- R6: `rd_oce` has no effect on the bypass output and no effect on writes.
- R7: `rd_srst`=1 at a `rd_clk` edge drives every output register to zero at that edge, regardless of the enables. Stored words are unchanged, so a later read returns them.
- R8: When `bank_sel`≠`BANK_ID`, reads leave the output unchanged and writes store nothing.
- R9: Every word reads as zero before it is first written.
- R10: A read and a write to the same word at the same edge (shared clock) return the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_ce | input | 1 | Write-port clock enable |
| wr_en | input | 1 | Write strobe; 1 stores `wr_data` |
| wr_addr | input | 14 | Write address; low log2(DATA_W) bits ignored |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read-port clock |
| rd_ce | input | 1 | Read-port clock enable |
| rd_oce | input | 1 | Load enable of the pipelined output register |
| rd_srst | input | 1 | Synchronous clear of the output registers |
| rd_addr | input | 14 | Read address; low log2(DATA_W) bits ignored |
| bank_sel | input | 3 | Bank select; must equal BANK_ID for any access |
| rd_data | output | DATA_W | Read word |

## Verification
Seven instances, covering all five widths in bypass mode plus two widths in pipelined mode, run side by side on the same stimulus. This shows whether the address mapping and lane placement hold for every shape.

Random traffic is confined to two small address windows so that reads often hit words just written. It mixes enables, bank misses, output-enable gaps and occasional resets. This separates correct latency and hold behaviour from stale or early data.

Directed cases target specific behaviours:
- words that differ only in ignored address bits;
- same-edge read and write to one word;
- writes blocked by each missing qualifier;
- a reset in mid-sequence followed by a re-read that must return the surviving contents.

// File: rtl/aspect_ram_pkg.sv
package aspect_ram_pkg;
   localparam int RAM_BITS = 16384;
   localparam int ROW_BITS = 16;
   localparam int ADDR_W   = $clog2(RAM_BITS);
   localparam int ROWS     = RAM_BITS / ROW_BITS;
   localparam int ROW_AW   = $clog2(ROWS);
   localparam int OFF_W    = $clog2(ROW_BITS);
   localparam int BANK_W   = 3;

   function automatic bit width_legal(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
   endfunction
endpackage

// File: rtl/asr_addr_decode.sv
module asr_addr_decode
   import aspect_ram_pkg::*;
#(
   parameter int                DATA_W  = 16,
   parameter logic [BANK_W-1:0] BANK_ID = '0
) (
   input  logic                en,
   input  logic [BANK_W-1:0]   bank_sel,
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit,
   output logic [ROW_AW-1:0]   row,
   output logic [OFF_W-1:0]    bit_off
);
   // Clearing the low log2(DATA_W) bits of the in-row offset aligns the lane.
   localparam logic [OFF_W-1:0] OFF_MASK = OFF_W'(ROW_BITS - DATA_W);

   assign hit     = en && (bank_sel == BANK_ID);
   assign row     = addr[ADDR_W-1:OFF_W];
   assign bit_off = addr[OFF_W-1:0] & OFF_MASK;
endmodule

// File: rtl/asr_array.sv
module asr_array
   import aspect_ram_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                wr_clk,
   input  logic                wr_stb,
   input  logic [ROW_AW-1:0]   wr_row,
   input  logic [OFF_W-1:0]    wr_off,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                rd_clk,
   input  logic                rd_stb,
   input  logic                rd_srst,
   input  logic [ROW_AW-1:0]   rd_row,
   input  logic [OFF_W-1:0]    rd_off,
   output logic [DATA_W-1:0]   rd_q
);
   // Fixed 16-bit rows; narrower shapes are lanes inside a row.
   logic [ROW_BITS-1:0] mem [ROWS] = '{default: '0};

   always_ff @(posedge wr_clk) begin
      if (wr_stb)
         mem[wr_row][wr_off +: DATA_W] <= wr_data;
   end

   // First read stage: the bypass output register.
   always_ff @(posedge rd_clk) begin
      if (rd_srst)
         rd_q <= '0;
      else if (rd_stb)
         rd_q <= mem[rd_row][rd_off +: DATA_W];
   end
endmodule

// File: rtl/asr_out_stage.sv
module asr_out_stage #(
   parameter int DATA_W   = 16,
   parameter int PIPE_OUT = 0
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              oce,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (PIPE_OUT != 0) begin : g_pipe
         logic [DATA_W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (srst)
               q_r <= '0;
            else if (oce)
               q_r <= d;
         end
         assign q = q_r;
      end else begin : g_bypass
         logic unused_oce;
         assign unused_oce = oce;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/aspect_sdp_ram.sv
module aspect_sdp_ram
   import aspect_ram_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter int                PIPE_OUT = 0,
   parameter logic [BANK_W-1:0] BANK_ID  = '0
) (
   input  logic               wr_clk,
   input  logic               wr_ce,
   input  logic               wr_en,
   input  logic [13:0]        wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_clk,
   input  logic               rd_ce,
   input  logic               rd_oce,
   input  logic               rd_srst,
   input  logic [13:0]        rd_addr,
   input  logic [2:0]         bank_sel,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int DEPTH = RAM_BITS / DATA_W;

   generate
      if (!width_legal(DATA_W)) begin : g_bad_width
         $error("aspect_sdp_ram: DATA_W %0d not in {1,2,4,8,16}", DATA_W);
      end
      if (PIPE_OUT != 0 && PIPE_OUT != 1) begin : g_bad_mode
         $error("aspect_sdp_ram: PIPE_OUT must be 0 or 1");
      end
      if (DEPTH * DATA_W != RAM_BITS) begin : g_bad_depth
         $error("aspect_sdp_ram: shape does not fill the array");
      end
   endgenerate

   logic              wr_hit, rd_hit;
   logic [ROW_AW-1:0] wr_row, rd_row;
   logic [OFF_W-1:0]  wr_off, rd_off;
   logic [DATA_W-1:0] arr_q;

   asr_addr_decode #(.DATA_W(DATA_W), .BANK_ID(BANK_ID)) u_wr_dec (
      .en(wr_ce), .bank_sel(bank_sel), .addr(wr_addr),
      .hit(wr_hit), .row(wr_row), .bit_off(wr_off)
   );

   asr_addr_decode #(.DATA_W(DATA_W), .BANK_ID(BANK_ID)) u_rd_dec (
      .en(rd_ce), .bank_sel(bank_sel), .addr(rd_addr),
      .hit(rd_hit), .row(rd_row), .bit_off(rd_off)
   );

   asr_array #(.DATA_W(DATA_W)) u_array (
      .wr_clk(wr_clk), .wr_stb(wr_hit && wr_en), .wr_row(wr_row),
      .wr_off(wr_off), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_stb(rd_hit), .rd_srst(rd_srst),
      .rd_row(rd_row), .rd_off(rd_off), .rd_q(arr_q)
   );

   asr_out_stage #(.DATA_W(DATA_W), .PIPE_OUT(PIPE_OUT)) u_out (
      .clk(rd_clk), .srst(rd_srst), .oce(rd_oce), .d(arr_q), .q(rd_data)
   );
endmodule

// File: rtl/aspect_sdp_ram_checks.sv
module aspect_sdp_ram_checks #(
   parameter int          DATA_W   = 16,
   parameter int          PIPE_OUT = 0,
   parameter logic [2:0]  BANK_ID  = '0
) (
   input logic              rd_clk,
   input logic              rd_srst,
   input logic              rd_ce,
   input logic              rd_oce,
   input logic [2:0]        bank_sel,
   input logic [DATA_W-1:0] arr_q,
   input logic [DATA_W-1:0] rd_data
);
   logic srst_q = 1'b0;

   always_ff @(posedge rd_clk) begin
      if (srst_q)
         a_r7_srst_clears: assert (rd_data == '0)
            else $error("R7: output not cleared after reset");
      srst_q <= rd_srst;
   end

   // R8: a read that misses (no enable or wrong bank) leaves stage one alone.
   a_r8_bank_gate: assert property (@(posedge rd_clk) disable iff (rd_srst)
      !(rd_ce && bank_sel == BANK_ID) |=> $stable(arr_q));

   generate
      if (PIPE_OUT != 0) begin : g_pipe_chk
         a_r5_oce_hold: assert property (@(posedge rd_clk) disable iff (rd_srst)
            !rd_oce |=> $stable(rd_data));
         a_r5_pipe_follow: assert property (@(posedge rd_clk) disable iff (rd_srst)
            rd_oce |=> rd_data == $past(arr_q));
      end else begin : g_byp_chk
         a_r4_miss_hold: assert property (@(posedge rd_clk) disable iff (rd_srst)
            !(rd_ce && bank_sel == BANK_ID) |=> $stable(rd_data));
         a_r6_oce_ignored: assert property (@(posedge rd_clk) disable iff (rd_srst)
            1'b1 |-> rd_data == arr_q);
      end
   endgenerate
endmodule

bind aspect_sdp_ram aspect_sdp_ram_checks #(
   .DATA_W(DATA_W), .PIPE_OUT(PIPE_OUT), .BANK_ID(BANK_ID)
) u_checks (
   .rd_clk(rd_clk), .rd_srst(rd_srst), .rd_ce(rd_ce), .rd_oce(rd_oce),
   .bank_sel(bank_sel), .arr_q(arr_q), .rd_data(rd_data)
);

// File: tb/aspect_sdp_ram_bench.sv
module aspect_sdp_ram_bench;
   localparam int N = 7;
   localparam int WID  [N] = '{1, 2, 4, 8, 16, 4, 16};
   localparam int PIPE [N] = '{0, 0, 0, 0, 0, 1, 1};
   localparam logic [2:0] BANK = 3'd5;

   // 50 MHz: 20 time units per period, units taken as ns
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        wr_ce = 0, wr_en = 0, rd_ce = 0, rd_oce = 0, rd_srst = 1;
   logic [13:0] wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  bank_sel = BANK;
   logic [15:0] dout [N];

   generate
      for (genvar g = 0; g < N; g++) begin : g_dut
         logic [WID[g]-1:0] q;
         aspect_sdp_ram #(.DATA_W(WID[g]), .PIPE_OUT(PIPE[g]), .BANK_ID(BANK)) u_aspect_sdp_ram (
            .wr_clk(clk), .wr_ce(wr_ce), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data[WID[g]-1:0]),
            .rd_clk(clk), .rd_ce(rd_ce), .rd_oce(rd_oce), .rd_srst(rd_srst),
            .rd_addr(rd_addr), .bank_sel(bank_sel), .rd_data(q)
         );
         assign dout[g] = 16'(q);
      end
   endgenerate

   // Reference model: flat 16384-bit image per instance, word at addr with low bits cleared
   bit          mdl [N][16384];
   logic [15:0] e1 [N];
   logic [15:0] e2 [N];
   int nchk = 0, nfail = 0;
   bit done = 0;

   function automatic logic [15:0] mread(input int g, input logic [13:0] a);
      int w = WID[g];
      int base = int'(a) & ~(w - 1);
      logic [15:0] v = '0;
      for (int b = 0; b < w; b++) v[b] = mdl[g][base + b];
      return v;
   endfunction

   task automatic check(input string tag, input int g, input logic [15:0] act,
                        input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s inst %0d width %0d pipe %0d: actual %h expected %h",
                  tag, g, WID[g], PIPE[g], act, exp);
      end
   endtask

   // Called at a negedge with inputs set; returns at the following negedge.
   task automatic tick(input string tag);
      logic [15:0] n1 [N];
      logic [15:0] n2 [N];
      bit hit = (bank_sel == BANK);
      for (int g = 0; g < N; g++) begin
         n1[g] = rd_srst ? 16'h0 : ((rd_ce && hit) ? mread(g, rd_addr) : e1[g]);
         n2[g] = rd_srst ? 16'h0 : (rd_oce ? e1[g] : e2[g]);
      end
      if (wr_ce && wr_en && hit) begin
         for (int g = 0; g < N; g++) begin
            int base = int'(wr_addr) & ~(WID[g] - 1);
            for (int b = 0; b < WID[g]; b++) mdl[g][base + b] = wr_data[b];
         end
      end
      @(posedge clk);
      for (int g = 0; g < N; g++) begin
         e1[g] = n1[g];
         e2[g] = n2[g];
      end
      @(negedge clk);
      for (int g = 0; g < N; g++)
         check(tag, g, dout[g], (PIPE[g] != 0) ? e2[g] : e1[g]);
   endtask

   task automatic setw(input logic ce, input logic en, input logic [13:0] a,
                       input logic [15:0] d);
      wr_ce = ce; wr_en = en; wr_addr = a; wr_data = d;
   endtask

   task automatic setr(input logic ce, input logic oce, input logic [13:0] a);
      rd_ce = ce; rd_oce = oce; rd_addr = a;
   endtask

   function automatic logic [13:0] pick_addr();
      logic [13:0] a = 14'($urandom_range(0, 63));
      if ($urandom_range(0, 1) != 0) a = a | 14'h3FC0;
      return a;
   endfunction

   initial begin
      void'($urandom(32'h5EED));
      for (int g = 0; g < N; g++) begin e1[g] = '0; e2[g] = '0; end
      @(negedge clk);
      // R7: reset state
      tick("R7");
      tick("R7");
      rd_srst = 0;

      // R9: untouched words read zero
      setr(1, 1, 14'h0000); tick("R9");
      setr(1, 1, 14'h2345); tick("R9");
      setr(1, 1, 14'h3FFF); tick("R9");
      tick("R9");

      // R2: low address bits ignored per width
      setw(1, 1, 14'h0013, 16'hA5C3); setr(0, 1, 14'h0); tick("R2");
      setw(0, 0, 14'h0, 16'h0);
      setr(1, 1, 14'h0010); tick("R2");
      setr(1, 1, 14'h0013); tick("R2");
      setr(1, 1, 14'h0012); tick("R2");
      setr(1, 1, 14'h001F); tick("R2");
      tick("R2");

      // R10: same-edge read and write to one word returns old contents
      setw(1, 1, 14'h0100, 16'h1234); setr(0, 1, 14'h0); tick("R10");
      setw(1, 1, 14'h0100, 16'h5678); setr(1, 1, 14'h0100); tick("R10");
      setw(0, 0, 14'h0, 16'h0); tick("R10");
      tick("R10");

      // R8: wrong bank blocks writes and reads
      bank_sel = 3'd2;
      setw(1, 1, 14'h0200, 16'hFFFF); setr(1, 1, 14'h0100); tick("R8");
      setw(0, 0, 14'h0, 16'h0); tick("R8");
      bank_sel = BANK;
      setr(1, 1, 14'h0200); tick("R8");
      tick("R8");

      // R3: missing wr_ce or wr_en stores nothing
      setw(0, 1, 14'h0300, 16'hBEEF); setr(0, 1, 14'h0); tick("R3");
      setw(1, 0, 14'h0300, 16'hCAFE); tick("R3");
      setw(0, 0, 14'h0, 16'h0); setr(1, 1, 14'h0300); tick("R3");
      tick("R3");

      // R6: oce low, bypass still follows reads, pipe holds
      setr(1, 0, 14'h0013); tick("R6");
      setr(1, 0, 14'h0100); tick("R6");
      setw(1, 1, 14'h0013, 16'h0F0F); setr(1, 0, 14'h0010); tick("R6");
      setw(0, 0, 14'h0, 16'h0); setr(0, 1, 14'h0); tick("R6");

      // R7: reset mid-sequence clears outputs, contents survive
      setw(1, 1, 14'h0040, 16'h9E37); tick("R7");
      setw(0, 0, 14'h0, 16'h0); setr(1, 1, 14'h0040); tick("R7");
      tick("R7");
      rd_srst = 1; tick("R7");
      rd_srst = 0; setr(0, 1, 14'h0); tick("R7");
      setr(1, 1, 14'h0040); tick("R7");
      tick("R7");

      // Random traffic over every width
      for (int i = 0; i < 6000; i++) begin
         setw($urandom_range(0, 9) < 8, $urandom_range(0, 3) != 0,
              pick_addr(), 16'($urandom));
         setr($urandom_range(0, 9) < 7, $urandom_range(0, 3) != 0, pick_addr());
         bank_sel = ($urandom_range(0, 9) == 0) ? 3'd2 : BANK;
         rd_srst  = ($urandom_range(0, 49) == 0);
         tick("R1 R4 R5 R6");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule